// File: doc/BRIEF.md
# Parallel ADC Burst Read Controller

This block runs a multichannel converter over a shared 16-bit bidirectional bus. A rate counter issues one-cycle conversion-start pulses. After each pulse the controller waits for the converter's busy line to rise and then fall. It then reads a programmable number of words with an active-low read strobe and presents each word on a valid/data/sync stream. Sync marks the first word of every burst.

Between bursts, the same bus serves single software accesses to the converter's internal registers. A write drives a word onto the bus under an active-low write strobe. A read places the returned word in a read-data output. The tri-state control releases the bus whenever the block is not writing.

The control inputs are plain levels and one-cycle request pulses: a run bit, a conversion enable, a period, a burst length and the write word. While the run bit is 0, the block is held idle.

Top module: `adcp_burst_ctrl`

## Requirements
- R1: While `rst` is 1 or `ctl_run` is 0, `rd_n`=1, `wr_n`=1, `bus_t`=1, and `cnv_start`, `st_valid` and `st_sync` are 0. Software requests made in this state are dropped and never performed later.
- R2: With `ctl_run`=1, `ctl_conv_en`=1 and `ctl_rate`=P (P>=2), a timer produces a tick on every P-th rising edge, counted from the first edge at which both bits are 1. A tick accepted while the controller is idle sets `cnv_start` to 1 for exactly one cycle.
- R3: While `ctl_conv_en` is 0, `cnv_start` stays 0 and the timer restarts from zero.
- R4: After a conversion pulse, no read strobe is issued until `adc_busy` has been sampled 1 and then 0. The first `rd_n` low follows the edge at which `adc_busy` is first sampled 0 after being 1.
- R5: Every strobe on `rd_n` or `wr_n` is low for exactly 2 cycles and then high for at least 1 cycle.
- R6: A burst reads `ctl_burst_len`+1 words, so the length field (words minus one, 0 to 31) gives 1 to 32 words. The field is sampled when the burst starts.
- R7: `bus_i` is captured at the edge where `rd_n` returns to 1. During a burst, `st_valid` is 1 for exactly that one cycle, with the captured word on `st_data`.
- R8: `st_sync` is 1 together with `st_valid` on the first word of each burst and is 0 on every other word.
- R9: A timer tick that occurs while a burst, its busy wait or a software access is in progress is skipped. No `cnv_start` is produced for it, and the timer keeps its period.
- R10: A software write drives `bus_t`=0 and `bus_o`=the requested word for the 2 low cycles of `wr_n` and the following high cycle. `bus_t` is 1 at all other times.
- R11: A software read issues one `rd_n` strobe and loads the captured word into `sw_rd_data`, with no `st_valid` pulse.
- R12: A software request that arrives during a burst waits until the burst is over. When the controller is idle, a timer tick wins over a pending write, and a pending write wins over a pending read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_run | input | 1 | 0 holds the block idle, 1 lets it operate |
| ctl_conv_en | input | 1 | Enables conversion-start generation |
| ctl_rate | input | 32 | Conversion period in clock cycles |
| ctl_burst_len | input | 5 | Words per burst minus one |
| sw_wr_req | input | 1 | One-cycle request for a register write |
| sw_wr_data | input | 16 | Word to write, taken with the request |
| sw_rd_req | input | 1 | One-cycle request for a register read |
| sw_rd_data | output | 16 | Word returned by the last software read |
| cnv_start | output | 1 | Conversion-start pulse to the converter |
| adc_busy | input | 1 | Converter busy, 1 while converting |
| bus_i | input | 16 | Data from the bus |
| bus_o | output | 16 | Data driven onto the bus |
| bus_t | output | 1 | Tri-state control, 1 = released |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| st_valid | output | 1 | Sample word valid |
| st_data | output | 16 | Sample word |
| st_sync | output | 1 | First word of a burst |

## Verification
The hardest situation to reach is a conversion tick or a software request that lands in the middle of a long burst. This is the case where a tick must be dropped and a write must wait.

The stimulus sets a period shorter than a full 32-word burst, so ticks fall inside bursts on their own. It also issues a write request right after a conversion pulse, while the busy wait is still under way.

A cycle-accurate model in the bench tracks the skipped ticks and the deferred write. It compares every strobe, the bus direction and the stream on each cycle.

// File: rtl/adcp_pkg.sv
package adcp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_BRD_LO,
    ST_BRD_HI,
    ST_SRD_LO,
    ST_SRD_HI,
    ST_WR_LO,
    ST_WR_HI
  } adcp_state_e;

  function automatic int unsigned ph_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/adcp_conv_timer.sv
module adcp_conv_timer #(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] last;
  logic              at_end;

  assign last   = rate - RATE_W'(1);
  assign at_end = (cnt_q >= last);
  assign tick   = run && en && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run || !en) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + RATE_W'(1);
    end
  end

  // R3
  no_tick_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);

endmodule

// File: rtl/adcp_sw_req.sv
module adcp_sw_req #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              wr_take,
  input  logic              rd_take,
  output logic              wr_pend,
  output logic              rd_pend,
  output logic [DATA_W-1:0] wr_word
);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      wr_pend <= 1'b0;
      rd_pend <= 1'b0;
      wr_word <= '0;
    end else begin
      if (wr_req) begin
        wr_pend <= 1'b1;
        wr_word <= wr_data;
      end else if (wr_take) begin
        wr_pend <= 1'b0;
      end
      if (rd_req) begin
        rd_pend <= 1'b1;
      end else if (rd_take) begin
        rd_pend <= 1'b0;
      end
    end
  end

  // R12
  take_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_take |-> wr_pend) and (rd_take |-> rd_pend));

endmodule

// File: rtl/adcp_bus_fsm.sv
module adcp_bus_fsm
  import adcp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int STB_LO = 2,
  parameter int STB_HI = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_pend,
  input  logic              rd_pend,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              busy,
  input  logic [DATA_W-1:0] bus_i,
  output logic              wr_take,
  output logic              rd_take,
  output logic              cnv_start,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_t,
  output logic [DATA_W-1:0] bus_o,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              st_sync,
  output logic [DATA_W-1:0] sw_rd_data
);

  localparam int PH_W = ph_bits(STB_LO, STB_HI);
  localparam logic [PH_W-1:0] LO_LAST = PH_W'(STB_LO - 1);
  localparam logic [PH_W-1:0] HI_LAST = PH_W'(STB_HI - 1);

  adcp_state_e      st_q;
  logic [PH_W-1:0]  ph_q;
  logic [LEN_W-1:0] word_q;
  logic [LEN_W-1:0] len_q;
  logic             busy_q;
  logic             idle;
  logic             busy_fall;
  logic             lo_done;
  logic             hi_done;

  assign idle      = (st_q == ST_IDLE);
  assign busy_fall = busy_q && !busy;
  assign lo_done   = (ph_q == LO_LAST);
  assign hi_done   = (ph_q == HI_LAST);
  assign wr_take   = run && idle && !tick && wr_pend;
  assign rd_take   = run && idle && !tick && !wr_pend && rd_pend;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st_q       <= ST_IDLE;
      ph_q       <= '0;
      word_q     <= '0;
      len_q      <= '0;
      busy_q     <= 1'b0;
      cnv_start  <= 1'b0;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      bus_t      <= 1'b1;
      bus_o      <= '0;
      st_valid   <= 1'b0;
      st_sync    <= 1'b0;
      st_data    <= '0;
      sw_rd_data <= '0;
    end else begin
      busy_q    <= busy;
      cnv_start <= 1'b0;
      st_valid  <= 1'b0;
      st_sync   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          ph_q <= '0;
          if (tick) begin
            cnv_start <= 1'b1;
            st_q      <= ST_CONV;
          end else if (wr_pend) begin
            wr_n  <= 1'b0;
            bus_t <= 1'b0;
            bus_o <= wr_word;
            st_q  <= ST_WR_LO;
          end else if (rd_pend) begin
            rd_n <= 1'b0;
            st_q <= ST_SRD_LO;
          end
        end
        ST_CONV: begin
          if (busy_fall) begin
            rd_n   <= 1'b0;
            ph_q   <= '0;
            word_q <= '0;
            len_q  <= burst_len;
            st_q   <= ST_BRD_LO;
          end
        end
        ST_BRD_LO: begin
          if (lo_done) begin
            rd_n     <= 1'b1;
            ph_q     <= '0;
            st_valid <= 1'b1;
            st_data  <= bus_i;
            st_sync  <= (word_q == '0);
            st_q     <= ST_BRD_HI;
          end else begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        ST_BRD_HI: begin
          if (hi_done) begin
            ph_q <= '0;
            if (word_q == len_q) begin
              st_q <= ST_IDLE;
            end else begin
              word_q <= word_q + LEN_W'(1);
              rd_n   <= 1'b0;
              st_q   <= ST_BRD_LO;
            end
          end else begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        ST_SRD_LO: begin
          if (lo_done) begin
            rd_n       <= 1'b1;
            ph_q       <= '0;
            sw_rd_data <= bus_i;
            st_q       <= ST_SRD_HI;
          end else begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        ST_SRD_HI: begin
          if (hi_done) begin
            ph_q <= '0;
            st_q <= ST_IDLE;
          end else begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        ST_WR_LO: begin
          if (lo_done) begin
            wr_n <= 1'b1;
            ph_q <= '0;
            st_q <= ST_WR_HI;
          end else begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        ST_WR_HI: begin
          if (hi_done) begin
            bus_t <= 1'b1;
            ph_q  <= '0;
            st_q  <= ST_IDLE;
          end else begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  idle_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (rd_n && wr_n && bus_t && !st_valid && !cnv_start));

  // R2
  cnv_one_cycle_chk: assert property (@(posedge clk) disable iff (rst || !run)
    cnv_start |=> !cnv_start);

  // R5
  rd_low_two_chk: assert property (@(posedge clk) disable iff (rst || !run)
    $fell(rd_n) |=> !rd_n);

  // R5
  wr_low_two_chk: assert property (@(posedge clk) disable iff (rst || !run)
    $fell(wr_n) |=> !wr_n);

  // R7
  valid_on_rise_chk: assert property (@(posedge clk) disable iff (rst || !run)
    st_valid |-> (rd_n && $past(!rd_n)));

  // R8
  sync_with_valid_chk: assert property (@(posedge clk) disable iff (rst || !run)
    st_sync |-> st_valid);

  // R10
  drive_while_write_chk: assert property (@(posedge clk) disable iff (rst || !run)
    !wr_n |-> !bus_t);

  // R5
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

endmodule

// File: rtl/adcp_burst_ctrl.sv
module adcp_burst_ctrl #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int RATE_W = 32,
  parameter int STB_LO = 2,
  parameter int STB_HI = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_run,
  input  logic              ctl_conv_en,
  input  logic [RATE_W-1:0] ctl_rate,
  input  logic [LEN_W-1:0]  ctl_burst_len,
  input  logic              sw_wr_req,
  input  logic [DATA_W-1:0] sw_wr_data,
  input  logic              sw_rd_req,
  output logic [DATA_W-1:0] sw_rd_data,
  output logic              cnv_start,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_t,
  output logic              rd_n,
  output logic              wr_n,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              st_sync
);

  logic              tick;
  logic              wr_pend;
  logic              rd_pend;
  logic              wr_take;
  logic              rd_take;
  logic [DATA_W-1:0] wr_word;

  adcp_conv_timer #(.RATE_W(RATE_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (ctl_run),
    .en   (ctl_conv_en),
    .rate (ctl_rate),
    .tick (tick)
  );

  adcp_sw_req #(.DATA_W(DATA_W)) u_req (
    .clk     (clk),
    .rst     (rst),
    .run     (ctl_run),
    .wr_req  (sw_wr_req),
    .wr_data (sw_wr_data),
    .rd_req  (sw_rd_req),
    .wr_take (wr_take),
    .rd_take (rd_take),
    .wr_pend (wr_pend),
    .rd_pend (rd_pend),
    .wr_word (wr_word)
  );

  adcp_bus_fsm #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .STB_LO (STB_LO),
    .STB_HI (STB_HI)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .run        (ctl_run),
    .tick       (tick),
    .wr_pend    (wr_pend),
    .rd_pend    (rd_pend),
    .wr_word    (wr_word),
    .burst_len  (ctl_burst_len),
    .busy       (adc_busy),
    .bus_i      (bus_i),
    .wr_take    (wr_take),
    .rd_take    (rd_take),
    .cnv_start  (cnv_start),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .bus_t      (bus_t),
    .bus_o      (bus_o),
    .st_valid   (st_valid),
    .st_data    (st_data),
    .st_sync    (st_sync),
    .sw_rd_data (sw_rd_data)
  );

endmodule

// File: tb/tb_adcp_burst_ctrl.sv
module tb_adcp_burst_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        en = 1'b0;
  logic [31:0] rate = 32'd50;
  logic [4:0]  blen = 5'd0;
  logic        wreq = 1'b0;
  logic [15:0] wdat = 16'h0;
  logic        rreq = 1'b0;
  logic [15:0] sw_rd_data, bus_o, st_data, bus_i;
  logic        cnv_start, bus_t, rd_n, wr_n, st_valid, st_sync;
  logic        adc_busy = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcp_burst_ctrl dut (
    .clk(clk), .rst(rst), .ctl_run(run), .ctl_conv_en(en), .ctl_rate(rate),
    .ctl_burst_len(blen), .sw_wr_req(wreq), .sw_wr_data(wdat), .sw_rd_req(rreq),
    .sw_rd_data(sw_rd_data), .cnv_start(cnv_start), .adc_busy(adc_busy),
    .bus_i(bus_i), .bus_o(bus_o), .bus_t(bus_t), .rd_n(rd_n), .wr_n(wr_n),
    .st_valid(st_valid), .st_data(st_data), .st_sync(st_sync)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- converter model ----------------
  int   idx = 0;
  int   bcnt = 0;
  logic prev_rdn = 1'b1;
  logic prev_wrn = 1'b1;
  logic [15:0] dev_reg = 16'h0;
  int   r4_viol = 0;

  assign bus_i = rd_n ? 16'hDEAD : (16'h1000 + 16'(idx));

  always @(negedge clk) begin
    if (adc_busy && !rd_n) r4_viol++;
    if (!prev_rdn && rd_n) idx++;
    if (!prev_wrn && wr_n && !bus_t) dev_reg = bus_o;
    prev_rdn = rd_n;
    prev_wrn = wr_n;
    if (cnv_start) bcnt = BUSY_CYC;
    adc_busy = (bcnt > 0);
    if (bcnt > 0) bcnt--;
  end

  // ---------------- reference model ----------------
  localparam int M_IDLE = 0, M_CONV = 1, M_BL = 2, M_BH = 3,
                 M_SL = 4, M_SH = 5, M_WL = 6, M_WH = 7;
  int   m_state = M_IDLE;
  int   m_left = 0;
  int   m_rem = 0;
  bit   m_first = 0;
  bit   m_bq = 0;
  bit   pw = 0, pr = 0;
  logic [15:0] pwd = 16'h0;
  longint tcnt = 0;
  logic e_rdn = 1, e_wrn = 1, e_t = 1, e_cnv = 0, e_val = 0, e_sync = 0;
  logic [15:0] e_bo = 0, e_data = 0, e_srd = 0;

  always @(posedge clk) begin
    bit tk, wt, rt;
    started = 1;
    if (rst || !run) begin
      m_state = M_IDLE; m_left = 0; m_rem = 0; m_first = 0; m_bq = 0;
      pw = 0; pr = 0; pwd = 0; tcnt = 0;
      e_rdn = 1; e_wrn = 1; e_t = 1; e_cnv = 0; e_val = 0; e_sync = 0;
      e_bo = 0; e_data = 0; e_srd = 0;
    end else begin
      tk = en && (tcnt >= longint'(rate) - 1);
      if (!en || tcnt >= longint'(rate) - 1) tcnt = 0; else tcnt++;
      wt = 0; rt = 0;
      e_cnv = 0; e_val = 0; e_sync = 0;
      case (m_state)
        M_IDLE: begin
          if (tk) begin e_cnv = 1; m_state = M_CONV; end
          else if (pw) begin wt = 1; e_wrn = 0; e_t = 0; e_bo = pwd; m_left = 2; m_state = M_WL; end
          else if (pr) begin rt = 1; e_rdn = 0; m_left = 2; m_state = M_SL; end
        end
        M_CONV: if (m_bq && !adc_busy) begin
          e_rdn = 0; m_left = 2; m_rem = int'(blen) + 1; m_first = 1; m_state = M_BL;
        end
        M_BL: begin
          m_left--;
          if (m_left == 0) begin
            e_rdn = 1; e_val = 1; e_sync = m_first; m_first = 0; e_data = bus_i;
            m_rem--; m_left = 1; m_state = M_BH;
          end
        end
        M_BH: begin
          m_left--;
          if (m_left == 0) begin
            if (m_rem == 0) m_state = M_IDLE;
            else begin e_rdn = 0; m_left = 2; m_state = M_BL; end
          end
        end
        M_SL: begin
          m_left--;
          if (m_left == 0) begin e_rdn = 1; e_srd = bus_i; m_left = 1; m_state = M_SH; end
        end
        M_SH: begin m_left--; if (m_left == 0) m_state = M_IDLE; end
        M_WL: begin
          m_left--;
          if (m_left == 0) begin e_wrn = 1; m_left = 1; m_state = M_WH; end
        end
        M_WH: begin m_left--; if (m_left == 0) begin e_t = 1; m_state = M_IDLE; end end
        default: m_state = M_IDLE;
      endcase
      m_bq = adc_busy;
      if (wreq) begin pw = 1; pwd = wdat; end else if (wt) pw = 0;
      if (rreq) pr = 1; else if (rt) pr = 0;
    end
  end

  // ---------------- per-cycle comparison and counters ----------------
  int n_cnv = 0, n_val = 0, n_sync = 0, r12_viol = 0;

  always @(negedge clk) begin
    if (started && !done) begin
      chk(rd_n === e_rdn, "R5 rd_n", rd_n, e_rdn);
      chk(wr_n === e_wrn, "R5 wr_n", wr_n, e_wrn);
      chk(bus_t === e_t, "R10 bus_t", bus_t, e_t);
      if (!e_t) chk(bus_o === e_bo, "R10 bus_o", bus_o, e_bo);
      chk(cnv_start === e_cnv, "R2 cnv_start", cnv_start, e_cnv);
      chk(st_valid === e_val, "R7 st_valid", st_valid, e_val);
      chk(st_sync === e_sync, "R8 st_sync", st_sync, e_sync);
      if (e_val) chk(st_data === e_data, "R7 st_data", st_data, e_data);
      chk(sw_rd_data === e_srd, "R11 sw_rd_data", sw_rd_data, e_srd);
      if (cnv_start) n_cnv++;
      if (st_valid) n_val++;
      if (st_sync) n_sync++;
      if (!wr_n && (m_state == M_BL || m_state == M_BH)) r12_viol++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_counts();
    n_cnv = 0; n_val = 0; n_sync = 0;
  endtask

  task automatic pulse_wr(input logic [15:0] d);
    @(negedge clk); wreq = 1'b1; wdat = d;
    @(negedge clk); wreq = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rreq = 1'b1;
    @(negedge clk); rreq = 1'b0;
  endtask

  task automatic burst_run(input logic [31:0] r, input logic [4:0] l, input int win,
                           input string tag);
    clr_counts();
    @(negedge clk); rate = r; blen = l; en = 1'b1;
    wait_cyc(win);
    @(negedge clk); en = 1'b0;
    wait_cyc(250);
    chk(n_cnv > 0, {tag, " bursts seen"}, n_cnv, 1);
    chk(n_val == (int'(l) + 1) * n_cnv, {tag, " words per burst"}, n_val, (int'(l) + 1) * n_cnv);
    chk(n_sync == n_cnv, "R8 one sync per burst", n_sync, n_cnv);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] reg_before;
    int i0;
    wait_cyc(5);
    // R1: reset state
    chk(rd_n && wr_n && bus_t, "R1 strobes idle in reset", {rd_n, wr_n, bus_t}, 3'b111);
    chk(!cnv_start && !st_valid && !st_sync, "R1 outputs low in reset",
        {cnv_start, st_valid, st_sync}, 0);
    @(negedge clk); rst = 1'b0;
    // R1: request while run is 0 is dropped
    reg_before = dev_reg;
    pulse_wr(16'h5A5A);
    wait_cyc(10);
    chk(wr_n && bus_t, "R1 no write while stopped", {wr_n, bus_t}, 2'b11);
    @(negedge clk); run = 1'b1;
    wait_cyc(10);
    chk(dev_reg == reg_before, "R1 dropped request not replayed", dev_reg, reg_before);

    // R3: enable low, no pulses
    clr_counts();
    wait_cyc(100);
    chk(n_cnv == 0, "R3 no pulse when disabled", n_cnv, 0);

    // R10: software write
    pulse_wr(16'hBEEF);
    wait_cyc(10);
    chk(dev_reg == 16'hBEEF, "R10 device got written word", dev_reg, 16'hBEEF);

    // R11: software read
    i0 = idx;
    clr_counts();
    pulse_rd();
    wait_cyc(10);
    chk(sw_rd_data == 16'h1000 + 16'(i0), "R11 read word", sw_rd_data, 16'h1000 + 16'(i0));
    chk(n_val == 0, "R11 no stream pulse", n_val, 0);

    // R6, R2, R4: bursts of several lengths
    burst_run(32'd60, 5'd0, 300, "R6 len0");
    burst_run(32'd60, 5'd3, 300, "R6 len3");
    burst_run(32'd150, 5'd31, 500, "R6 len31");
    chk(r4_viol == 0, "R4 no strobe while busy", r4_viol, 0);

    // R9: period shorter than a burst, ticks skipped
    clr_counts();
    @(negedge clk); rate = 32'd20; blen = 5'd31; en = 1'b1;
    wait_cyc(400);
    @(negedge clk); en = 1'b0;
    wait_cyc(250);
    chk(n_cnv > 0 && n_cnv < 10, "R9 ticks skipped during burst", n_cnv, 4);
    chk(n_val == 32 * n_cnv, "R9 every accepted pulse read fully", n_val, 32 * n_cnv);

    // R12: write requested during busy wait waits for the burst
    @(negedge clk); rate = 32'd300; blen = 5'd15; en = 1'b1;
    while (!cnv_start) @(negedge clk);
    @(negedge clk); en = 1'b0;
    pulse_wr(16'hC0DE);
    wait_cyc(120);
    chk(r12_viol == 0, "R12 write deferred past burst", r12_viol, 0);
    chk(dev_reg == 16'hC0DE, "R12 deferred write performed", dev_reg, 16'hC0DE);
    chk(r4_viol == 0, "R4 no strobe while busy (final)", r4_viol, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule